// File: doc/BRIEF.md
# NAND Program and Erase Command Sequencer

This block orders the commands that change the contents of a serial NAND device. A caller gives it one request: either a page program (row address, column offset inside the on-die cache, byte count) or a block erase (row address). The sequencer then asks a separate frame engine for each command frame in turn. Each frame is described by an opcode, an address byte count, a right-aligned address and a data byte count. The frame engine owns the serial bit timing and the data bytes.

After the last modifying frame, the sequencer starts a ready-wait helper. The helper polls the device and returns the final status byte, or reports that it gave up. The sequencer turns that answer into a two-bit verdict and announces it with a single-cycle completion strobe. A write-enable frame always comes before the first modifying frame of every request. For a program, the caller chooses whether the load step clears the cache first or patches only the bytes it sends.

Top module: `nand_pe_seq`

## Requirements
- R1: During and right after reset, `busy`, `done`, `frm_valid` and `wait_start` are all low.
- R2: A program request produces exactly three frames, in this order: write-enable (opcode 0x06, zero address bytes, zero data bytes), then the load frame, then program-execute (opcode 0x10, three address bytes carrying the row, zero data bytes).
- R3: The load frame uses opcode 0x02 (cache cleared first) when `keep_cache` is 0 and opcode 0x84 (cache kept, bytes patched) when `keep_cache` is 1. It carries two address bytes holding the column and a data byte count equal to `data_len`.
- R4: An erase request produces exactly two frames: write-enable (0x06), then block-erase (opcode 0xD8, three address bytes carrying the row, zero data bytes). No load frame is sent.
- R5: No frame other than write-enable is presented in a request until a write-enable frame of that same request has been accepted.
- R6: Frame fields stay stable while `frm_valid` is high and `frm_ready` is low. After acceptance, `frm_valid` stays low until `frm_done` is seen. The next frame appears in the cycle after the edge that samples `frm_done`.
- R7: `wait_start` is a one-cycle pulse in the cycle after the edge that samples `frm_done` of the last frame. No frame is presented while it is high. The verdict is 1 (fail) if status bit 3 is set for a program or status bit 2 is set for an erase, and 0 (ok) otherwise. All other status bits are ignored.
- R8: If `wait_timeout` is high together with `wait_done`, the verdict is 2 (timeout) whatever the status byte holds. The value 3 never appears.
- R9: `busy` rises in the cycle after the edge that samples `start`. `done` is a one-cycle pulse in the cycle after the edge that samples `wait_done`, with `busy` still high. `busy` is low in the next cycle.
- R10: A `start` pulse seen while `busy` is high is ignored. The frames of the running request keep their original opcodes and addresses, and no extra request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| op_erase | input | 1 | 1 = block erase, 0 = page program |
| keep_cache | input | 1 | Program only: 1 = keep cache contents (0x84), 0 = clear cache (0x02) |
| row_addr | input | ROW_W (24) | Page or block row address |
| col_addr | input | COL_W (16) | Cache column offset for the load frame |
| data_len | input | LEN_W (12) | Byte count of the load frame |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | Verdict: 0 ok, 1 fail, 2 timeout |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | Frame engine accepts the request |
| frm_opcode | output | 8 | Command opcode |
| frm_addr_bytes | output | 2 | Number of address bytes (0, 2 or 3) |
| frm_addr | output | ADDR_W (24) | Right-aligned address |
| frm_data_len | output | LEN_W (12) | Data bytes sent after the address (0 = none) |
| frm_done | input | 1 | Accepted frame has finished on the wire |
| wait_start | output | 1 | One-cycle pulse that starts the ready-wait helper |
| wait_done | input | 1 | Ready-wait helper finished |
| wait_timeout | input | 1 | Ready-wait helper gave up (valid with wait_done) |
| wait_status | input | 8 | Final device status byte (valid with wait_done) |

## Verification
Every result of this block lands exactly one clock edge after the input that causes it. `busy` and the first frame follow `start` by one edge. Each next frame, or `wait_start`, follows the edge that samples `frm_done` by one edge. `frm_valid` drops one edge after the sampled `frm_ready`. `done` with its verdict follows `wait_done` by one edge. The bench drives every response on the falling edge and checks the outputs at the next falling edge, so each expected value sits half a cycle after the rising edge that produces it. The sweep runs all 256 status bytes for each of the three request kinds. It varies frame stalls, forces timeouts on a fixed subset, and sends stray start pulses during some requests.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;

  localparam logic [7:0] OPC_WREN       = 8'h06;
  localparam logic [7:0] OPC_LOAD_FRESH = 8'h02;
  localparam logic [7:0] OPC_LOAD_KEEP  = 8'h84;
  localparam logic [7:0] OPC_COMMIT     = 8'h10;
  localparam logic [7:0] OPC_ERASE      = 8'hD8;

  typedef enum logic [1:0] {
    STEP_NONE   = 2'd0,
    STEP_WREN   = 2'd1,
    STEP_LOAD   = 2'd2,
    STEP_COMMIT = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_FAIL    = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_WREN_REQ   = 4'd1,
    ST_WREN_RUN   = 4'd2,
    ST_LOAD_REQ   = 4'd3,
    ST_LOAD_RUN   = 4'd4,
    ST_COMMIT_REQ = 4'd5,
    ST_COMMIT_RUN = 4'd6,
    ST_POLL_KICK  = 4'd7,
    ST_POLL_RUN   = 4'd8,
    ST_REPORT     = 4'd9
  } state_e;

endpackage

// File: rtl/nand_pe_req.sv
module nand_pe_req #(
  parameter int ROW_W = 24,
  parameter int COL_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             erase_i,
  input  logic             keep_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             erase_q,
  output logic             keep_q,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic [LEN_W-1:0] len_q
);

  logic             erase_d;
  logic             keep_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    erase_d = erase_q;
    keep_d  = keep_q;
    row_d   = row_q;
    col_d   = col_q;
    len_d   = len_q;
    if (load_en) begin
      erase_d = erase_i;
      keep_d  = keep_i;
      row_d   = row_i;
      col_d   = col_i;
      len_d   = len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      keep_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
    end else begin
      erase_q <= erase_d;
      keep_q  <= keep_d;
      row_q   <= row_d;
      col_q   <= col_d;
      len_q   <= len_d;
    end
  end

endmodule

// File: rtl/nand_pe_fsm.sv
module nand_pe_fsm
  import nand_pe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  is_erase,
  input  logic  frm_ready,
  input  logic  frm_done,
  input  logic  wait_done,
  output step_e step,
  output logic  frm_valid,
  output logic  wait_start,
  output logic  busy,
  output logic  done,
  output logic  accept,
  output logic  capture
);

  state_e state_q;
  state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start)     state_d = ST_WREN_REQ;
      ST_WREN_REQ:   if (frm_ready) state_d = ST_WREN_RUN;
      ST_WREN_RUN:   if (frm_done)  state_d = is_erase ? ST_COMMIT_REQ : ST_LOAD_REQ;
      ST_LOAD_REQ:   if (frm_ready) state_d = ST_LOAD_RUN;
      ST_LOAD_RUN:   if (frm_done)  state_d = ST_COMMIT_REQ;
      ST_COMMIT_REQ: if (frm_ready) state_d = ST_COMMIT_RUN;
      ST_COMMIT_RUN: if (frm_done)  state_d = ST_POLL_KICK;
      ST_POLL_KICK:                 state_d = ST_POLL_RUN;
      ST_POLL_RUN:   if (wait_done) state_d = ST_REPORT;
      ST_REPORT:                    state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    step = STEP_NONE;
    unique case (state_q)
      ST_WREN_REQ, ST_WREN_RUN:     step = STEP_WREN;
      ST_LOAD_REQ, ST_LOAD_RUN:     step = STEP_LOAD;
      ST_COMMIT_REQ, ST_COMMIT_RUN: step = STEP_COMMIT;
      default:                      step = STEP_NONE;
    endcase
  end

  assign frm_valid  = (state_q == ST_WREN_REQ) || (state_q == ST_LOAD_REQ) ||
                      (state_q == ST_COMMIT_REQ);
  assign wait_start = (state_q == ST_POLL_KICK);
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_REPORT);
  assign accept     = (state_q == ST_IDLE) && start;
  assign capture    = (state_q == ST_POLL_RUN) && wait_done;

endmodule

// File: rtl/nand_pe_frame.sv
module nand_pe_frame
  import nand_pe_pkg::*;
#(
  parameter int ROW_W  = 24,
  parameter int COL_W  = 16,
  parameter int LEN_W  = 12,
  parameter int ADDR_W = 24
) (
  input  step_e             step,
  input  logic              is_erase,
  input  logic              keep,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        opcode,
  output logic [1:0]        addr_bytes,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  data_len
);

  logic [ADDR_W-1:0] row_ext;
  logic [ADDR_W-1:0] col_ext;

  generate
    if (ADDR_W > ROW_W) begin : g_row_pad
      assign row_ext = {{(ADDR_W-ROW_W){1'b0}}, row};
    end else begin : g_row_fit
      assign row_ext = row[ADDR_W-1:0];
    end
    if (ADDR_W > COL_W) begin : g_col_pad
      assign col_ext = {{(ADDR_W-COL_W){1'b0}}, col};
    end else begin : g_col_fit
      assign col_ext = col[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    opcode     = 8'h00;
    addr_bytes = 2'd0;
    addr       = '0;
    data_len   = '0;
    unique case (step)
      STEP_WREN: opcode = OPC_WREN;
      STEP_LOAD: begin
        opcode     = keep ? OPC_LOAD_KEEP : OPC_LOAD_FRESH;
        addr_bytes = 2'd2;
        addr       = col_ext;
        data_len   = len;
      end
      STEP_COMMIT: begin
        opcode     = is_erase ? OPC_ERASE : OPC_COMMIT;
        addr_bytes = 2'd3;
        addr       = row_ext;
      end
      default: opcode = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_pe_verdict.sv
module nand_pe_verdict
  import nand_pe_pkg::*;
#(
  parameter int STAT_W         = 8,
  parameter int PROG_FAIL_BIT  = 3,
  parameter int ERASE_FAIL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              is_erase,
  input  logic              timeout,
  input  logic [STAT_W-1:0] status,
  output logic [1:0]        result
);

  localparam logic [STAT_W-1:0] PROG_MASK  = STAT_W'(1) << PROG_FAIL_BIT;
  localparam logic [STAT_W-1:0] ERASE_MASK = STAT_W'(1) << ERASE_FAIL_BIT;

  logic       failed;
  res_e       res_d;
  logic [1:0] res_q;

  assign failed = |(status & (is_erase ? ERASE_MASK : PROG_MASK));

  always_comb begin
    res_d = res_e'(res_q);
    if (capture) begin
      if (timeout)     res_d = RES_TIMEOUT;
      else if (failed) res_d = RES_FAIL;
      else             res_d = RES_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= RES_OK;
    else        res_q <= res_d;
  end

  assign result = res_q;

endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_pe_pkg::*;
#(
  parameter int ROW_W          = 24,
  parameter int COL_W          = 16,
  parameter int LEN_W          = 12,
  parameter int ADDR_W         = 24,
  parameter int STAT_W         = 8,
  parameter int PROG_FAIL_BIT  = 3,
  parameter int ERASE_FAIL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic              keep_cache,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [LEN_W-1:0]  data_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [7:0]        frm_opcode,
  output logic [1:0]        frm_addr_bytes,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [LEN_W-1:0]  frm_data_len,
  input  logic              frm_done,
  output logic              wait_start,
  input  logic              wait_done,
  input  logic              wait_timeout,
  input  logic [STAT_W-1:0] wait_status
);

  logic             accept;
  logic             capture;
  logic             erase_q;
  logic             keep_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  step_e            step;

  nand_pe_req #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (accept),
    .erase_i (op_erase),
    .keep_i  (keep_cache),
    .row_i   (row_addr),
    .col_i   (col_addr),
    .len_i   (data_len),
    .erase_q (erase_q),
    .keep_q  (keep_q),
    .row_q   (row_q),
    .col_q   (col_q),
    .len_q   (len_q)
  );

  nand_pe_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_erase   (erase_q),
    .frm_ready  (frm_ready),
    .frm_done   (frm_done),
    .wait_done  (wait_done),
    .step       (step),
    .frm_valid  (frm_valid),
    .wait_start (wait_start),
    .busy       (busy),
    .done       (done),
    .accept     (accept),
    .capture    (capture)
  );

  nand_pe_frame #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_frame (
    .step       (step),
    .is_erase   (erase_q),
    .keep       (keep_q),
    .row        (row_q),
    .col        (col_q),
    .len        (len_q),
    .opcode     (frm_opcode),
    .addr_bytes (frm_addr_bytes),
    .addr       (frm_addr),
    .data_len   (frm_data_len)
  );

  nand_pe_verdict #(
    .STAT_W(STAT_W), .PROG_FAIL_BIT(PROG_FAIL_BIT), .ERASE_FAIL_BIT(ERASE_FAIL_BIT)
  ) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .is_erase (erase_q),
    .timeout  (wait_timeout),
    .status   (wait_status),
    .result   (result)
  );

endmodule

// File: rtl/nand_pe_checker.sv
module nand_pe_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [7:0]        frm_opcode,
  input logic [ADDR_W-1:0] frm_addr,
  input logic              wait_start
);

  logic wren_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          wren_seen <= 1'b0;
    else if (done)                                       wren_seen <= 1'b0;
    else if (frm_valid && frm_ready && frm_opcode == 8'h06) wren_seen <= 1'b1;
  end

  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_opcode != 8'h06) |-> wren_seen);                   // R5

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_opcode) && $stable(frm_addr))); // R6

  AST_WAIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |=> !wait_start);                                         // R7

  AST_WAIT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |-> !frm_valid);                                          // R7

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));                                          // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));                                          // R9

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);                                                      // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!frm_valid && !wait_start && !done));                     // R1

endmodule

bind nand_pe_seq nand_pe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .frm_valid  (frm_valid),
  .frm_ready  (frm_ready),
  .frm_opcode (frm_opcode),
  .frm_addr   (frm_addr),
  .wait_start (wait_start)
);

// File: tb/nand_pe_seq_bench.sv
`timescale 1ns/1ps
module nand_pe_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        op_erase;
  logic        keep_cache;
  logic [23:0] row_addr;
  logic [15:0] col_addr;
  logic [11:0] data_len;
  logic        busy;
  logic        done;
  logic [1:0]  result;
  logic        frm_valid;
  logic        frm_ready;
  logic [7:0]  frm_opcode;
  logic [1:0]  frm_addr_bytes;
  logic [23:0] frm_addr;
  logic [11:0] frm_data_len;
  logic        frm_done;
  logic        wait_start;
  logic        wait_done;
  logic        wait_timeout;
  logic [7:0]  wait_status;

  int checks;
  int errors;

  nand_pe_seq u_nand_pe_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .keep_cache(keep_cache), .row_addr(row_addr), .col_addr(col_addr),
    .data_len(data_len), .busy(busy), .done(done), .result(result),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_opcode(frm_opcode),
    .frm_addr_bytes(frm_addr_bytes), .frm_addr(frm_addr),
    .frm_data_len(frm_data_len), .frm_done(frm_done), .wait_start(wait_start),
    .wait_done(wait_done), .wait_timeout(wait_timeout), .wait_status(wait_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge where the frame must already be presented.
  task automatic do_frame(input logic [7:0] op, input logic [1:0] nb, input logic [23:0] ad,
                          input logic [11:0] ln, input int stall, input bit inject,
                          input string tag);
    chk(frm_valid == 1'b1, {tag, " valid"}, frm_valid, 1);
    chk(frm_opcode == op, {tag, " opcode"}, frm_opcode, op);
    chk(frm_addr_bytes == nb, {tag, " addr bytes"}, frm_addr_bytes, nb);
    chk(frm_addr == ad, {tag, " addr"}, frm_addr, ad);
    chk(frm_data_len == ln, {tag, " data len"}, frm_data_len, ln);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(frm_valid && frm_opcode == op && frm_addr == ad, "R6 hold while stalled", frm_opcode, op);
    end
    frm_ready = 1'b1;
    @(negedge clk);
    frm_ready = 1'b0;
    if (inject) begin  // R10 stray request while busy
      start      = 1'b1;
      op_erase   = ~op_erase;
      keep_cache = ~keep_cache;
      row_addr   = ~row_addr;
      col_addr   = ~col_addr;
    end
    for (int i = 0; i < 2; i++) begin
      chk(frm_valid == 1'b0, "R6 no frame before done", frm_valid, 0);
      @(negedge clk);
    end
    start    = 1'b0;
    frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
  endtask

  task automatic run_op(input bit er, input bit kp, input logic [23:0] row,
                        input logic [15:0] col, input logic [11:0] len,
                        input logic [7:0] st, input bit tmo, input int stall,
                        input bit inject);
    logic [1:0] exp_res;
    op_erase = er; keep_cache = kp; row_addr = row; col_addr = col; data_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy one edge after start", busy, 1);
    do_frame(8'h06, 2'd0, 24'd0, 12'd0, stall, inject, er ? "R4 wren" : "R2 wren");
    if (!er)
      do_frame(kp ? 8'h84 : 8'h02, 2'd2, {8'd0, col}, len, stall, 1'b0, "R3 load");
    do_frame(er ? 8'hD8 : 8'h10, 2'd3, row, 12'd0, stall, 1'b0, er ? "R4 erase" : "R2 execute");
    chk(wait_start == 1'b1 && frm_valid == 1'b0, "R7 wait_start after last frame", wait_start, 1);
    @(negedge clk);
    chk(wait_start == 1'b0, "R7 wait_start single cycle", wait_start, 0);
    for (int i = 0; i < stall; i++) begin
      chk(done == 1'b0 && busy == 1'b1, "R9 waiting", done, 0);
      @(negedge clk);
    end
    wait_status = st; wait_timeout = tmo; wait_done = 1'b1;
    @(negedge clk);
    wait_done = 1'b0; wait_timeout = 1'b0;
    if (tmo)     exp_res = 2'd2;
    else if (er) exp_res = {1'b0, st[2]};
    else         exp_res = {1'b0, st[3]};
    chk(done == 1'b1 && busy == 1'b1, "R9 done one edge after wait_done", done, 1);
    chk(result == exp_res, tmo ? "R8 timeout verdict" : "R7 status verdict", result, exp_res);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && frm_valid == 1'b0, "R9 R10 idle after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; op_erase = 1'b0; keep_cache = 1'b0;
    row_addr = '0; col_addr = '0; data_len = '0;
    frm_ready = 1'b0; frm_done = 1'b0;
    wait_done = 1'b0; wait_timeout = 1'b0; wait_status = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !frm_valid && !wait_start, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !frm_valid && !wait_start, "R1 after reset", busy, 0);
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 256; s++) begin
        logic [23:0] row;
        row = (24'(s) * 24'h010101) ^ (24'(k) << 20);
        run_op(k == 2, k == 1, row, 16'(s * 257), 12'(s + 1), 8'(s),
               (s % 7) == 3, s % 3, (s % 5) == 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule